// File: doc/BRIEF.md
# GPIO Pin Bank with Per-Pin Configuration and Input Sensing

The block is a bank of identical pin cells. Each pin has one 32-bit word on a simple memory-mapped register bus. The word holds the pin's data bit, a 3-bit mode, a peripheral function select, pull and drive-strength settings, Schmitt and input-enable flags, an interrupt group number and a lock flag. The bank drives the pad-side output value, the output enable and the peripheral select for every pin. It also passes the interrupt group number to the pending logic that sits beside it.

The pad input of each pin goes through a two-flop synchronizer. A third flop holds the previous synchronized sample, and edges are found by comparing the two. One 3-bit mode field selects the pin's behaviour. The pin can be an output driving its stored data bit, an input that raises no interrupt, or an input with one of five sense types: high level, low level, rising edge, falling edge or both edges. The sense logic produces a registered interrupt event per pin for the external pending registers. A read of the data bit gives the live synchronized pad level whenever the pin is not an output.

The pull, drive-strength, Schmitt and input-enable fields are stored and read back only. Their electrical effect belongs to the pad.

Top module: `gpio_pin_bank`

## Requirements
- R1: After reset every pin word reads 0x0000000E (mode 7 in bits 3:1, every other field 0). Bit 0 reads the pad level. pad_oe, pad_func, irq_grp and irq_event are all 0.
- R2: Pin i's word is at byte address 4*i. A write to an address that is not word-aligned, or whose word index is NUM_PINS or above, changes no pin. A read of such an address returns 0, and so does any cycle with bus_rd low.
- R3: The writable bits are 0, 3:1, 6:5, 8:7, 9, 11:10, 15, 18:16, 21 and 23:22, so the writable mask is 0x00E78FEF. All other bits read 0.
- R4: With mode 1 (bits 3:1 = 3'b001), pad_oe is 1 and pad_out equals the stored bit 0. With any other mode, pad_oe is 0.
- R5: With a mode other than 1, a read of bit 0 returns the pad level after two synchronizer flops. The new level is visible after the second rising clock edge that follows the pad change. With mode 1, bit 0 reads back the stored value.
- R6: Mode 2 (level high) holds irq_event at 1 while the synchronized level is 1, and mode 3 (level low) does the same while it is 0. The event begins on the first clock edge after the mode is written, when the level already holds. It clears on the third edge after the pad leaves the active level.
- R7: Mode 4 (rising) gives a one-cycle irq_event pulse for each 0-to-1 pad change, and mode 5 (falling) does the same for each 1-to-0 change. The pulse is high after the third rising edge that follows the pad change. The opposite edge gives no pulse.
- R8: Mode 6 gives a one-cycle irq_event pulse for both pad edges, with the same latency as R7.
- R9: Modes 0 and 7 never raise irq_event, and neither does a pin that has been in mode 1 since the cycle before.
- R10: pad_func[2i+1:2i] carries pin i's bits 6:5 (0 = plain GPIO, 1 to 3 = peripheral functions). irq_grp[3i+2:3i] carries its bits 18:16. Bits 8:7 hold the pull code: 0 off, 1 pull-down, 2 strong pull-up, 3 pull-up.
- R11: While a pin's lock bit (bit 21) is set, a write to that pin updates only bit 0 and bit 21. All other fields keep their values. Clearing bit 21 in such a write unlocks the pin for later writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, taken on the rising edge |
| bus_rd | input | 1 | Read strobe; bus_rdata is valid in the same cycle |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| pad_in | input | NUM_PINS | Asynchronous pad input levels |
| pad_out | output | NUM_PINS | Pad output values |
| pad_oe | output | NUM_PINS | Pad output enables |
| pad_func | output | 2*NUM_PINS | Peripheral select, 2 bits per pin |
| irq_grp | output | 3*NUM_PINS | Interrupt group number, 3 bits per pin |
| irq_event | output | NUM_PINS | Registered interrupt event per pin |

## Verification
The level modes are tested with the pad held at the active level and then released. This separates a sustained event from a pulse and fixes the clear latency. The edge modes are tested with separate rising and falling pad changes, sampled one cycle before, on and after the expected pulse. This exposes a wrong polarity, a pulse that is too wide and a miscounted synchronizer depth. The quiet modes and the output mode are tested by toggling the pad and checking that irq_event stays low. Further tests write all ones, write at unaligned and out-of-range addresses, and write to a locked word. These show the field mask, the address decode and the lock filtering through the read port and the pad outputs.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
// Package: field positions, masks and mode codes shared by the pin bank.
package gpio_pkg;
    localparam int CFG_W      = 32;
    localparam int DATA_BIT   = 0;
    localparam int MODE_LSB   = 1;
    localparam int FUNC_LSB   = 5;
    localparam int GRP_LSB    = 16;
    localparam int LOCK_BIT   = 21;

    // bits a write may touch when unlocked
    localparam logic [CFG_W-1:0] CFG_RW_MASK   = 32'h00E7_8FEF;
    // bits a write may touch when locked
    localparam logic [CFG_W-1:0] CFG_LOCK_MASK = 32'h0020_0001;
    localparam logic [CFG_W-1:0] CFG_RESET     = 32'h0000_000E;

    typedef enum logic [2:0] {
        MODE_IN_QUIET = 3'd0,
        MODE_OUT      = 3'd1,
        MODE_LVL_HI   = 3'd2,
        MODE_LVL_LO   = 3'd3,
        MODE_RISE     = 3'd4,
        MODE_FALL     = 3'd5,
        MODE_BOTH     = 3'd6,
        MODE_IN_OFF   = 3'd7
    } pin_mode_e;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
// Module: gpio_sync
// Flop chain that brings an asynchronous level into the clk domain.
// Assumes STAGES >= 2. The chain resets to 0.
module gpio_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // shift the pad level through the chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_pin_cell.sv
`timescale 1ns/1ps
// Module: gpio_pin_cell
// One pin: its configuration word, lock-filtered write, the input
// synchronizer, the sense logic and the read word.
// Assumes wr_en is already decoded for this pin.
module gpio_pin_cell
    import gpio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wdata,
    input  logic             pad_in,
    output logic [CFG_W-1:0] cfg_q,
    output logic [CFG_W-1:0] rd_word,
    output logic             pad_out,
    output logic             pad_oe,
    output logic             irq_event
);
    logic [CFG_W-1:0] cfg_r;
    logic [CFG_W-1:0] wmask;
    logic             lvl;
    logic             lvl_prev;
    logic             sense_hit;
    pin_mode_e        mode;

    gpio_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pad_in),
        .q    (lvl)
    );

    assign mode  = pin_mode_e'(cfg_r[MODE_LSB +: 3]);
    assign wmask = cfg_r[LOCK_BIT] ? CFG_LOCK_MASK : CFG_RW_MASK;

    // configuration word, updated only in its permitted bits
    always_ff @(posedge clk) begin
        if (!rst_n)     cfg_r <= CFG_RESET;
        else if (wr_en) cfg_r <= (cfg_r & ~wmask) | (wdata & wmask);
    end

    // sense condition for the current mode
    always_comb begin
        case (mode)
            MODE_LVL_HI: sense_hit = lvl;
            MODE_LVL_LO: sense_hit = !lvl;
            MODE_RISE:   sense_hit = lvl && !lvl_prev;
            MODE_FALL:   sense_hit = !lvl && lvl_prev;
            MODE_BOTH:   sense_hit = lvl ^ lvl_prev;
            default:     sense_hit = 1'b0;
        endcase
    end

    // previous sample and registered event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_prev  <= 1'b0;
            irq_event <= 1'b0;
        end else begin
            lvl_prev  <= lvl;
            irq_event <= sense_hit;
        end
    end

    assign cfg_q   = cfg_r;
    assign pad_oe  = (mode == MODE_OUT);
    assign pad_out = cfg_r[DATA_BIT];
    assign rd_word = {cfg_r[CFG_W-1:1], (mode == MODE_OUT) ? cfg_r[DATA_BIT] : lvl};
endmodule

// File: rtl/gpio_pin_bank.sv
`timescale 1ns/1ps
// Module: gpio_pin_bank
// Bank of NUM_PINS pin cells behind a word-per-pin register bus.
// Assumes NUM_PINS fits in the word index of ADDR_W byte addresses.
// Reads are combinational; writes take effect on the rising edge.
module gpio_pin_bank
    import gpio_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [CFG_W-1:0]      bus_wdata,
    output logic [CFG_W-1:0]      bus_rdata,
    input  logic [NUM_PINS-1:0]   pad_in,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [NUM_PINS-1:0]   pad_oe,
    output logic [2*NUM_PINS-1:0] pad_func,
    output logic [3*NUM_PINS-1:0] irq_grp,
    output logic [NUM_PINS-1:0]   irq_event
);
    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0]         word_idx;
    logic                      aligned;
    logic [NUM_PINS-1:0]       sel;
    logic [CFG_W-1:0]          rd_words [NUM_PINS];
    logic [NUM_PINS*CFG_W-1:0] cfg_flat;
    logic [CFG_W-1:0]          rd_acc;

    assign word_idx = bus_addr[ADDR_W-1:2];
    assign aligned  = (bus_addr[1:0] == 2'b00);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic [CFG_W-1:0] cfg_i;

        // address match for this pin
        assign sel[i] = aligned && (word_idx == WIDX_W'(i));

        gpio_pin_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (bus_wr && sel[i]),
            .wdata    (bus_wdata),
            .pad_in   (pad_in[i]),
            .cfg_q    (cfg_i),
            .rd_word  (rd_words[i]),
            .pad_out  (pad_out[i]),
            .pad_oe   (pad_oe[i]),
            .irq_event(irq_event[i])
        );

        assign cfg_flat[i*CFG_W +: CFG_W] = cfg_i;
        assign pad_func[2*i +: 2]         = cfg_i[FUNC_LSB +: 2];
        assign irq_grp[3*i +: 3]          = cfg_i[GRP_LSB +: 3];
    end

    // read multiplexer over the selected pin
    always_comb begin
        rd_acc = '0;
        for (int i = 0; i < NUM_PINS; i++)
            if (sel[i]) rd_acc |= rd_words[i];
    end

    assign bus_rdata = bus_rd ? rd_acc : '0;
endmodule

// File: rtl/gpio_pin_bank_chk.sv
`timescale 1ns/1ps
// Module: gpio_pin_bank_chk
// Property checker bound to gpio_pin_bank. It watches the stored words,
// the events and the read port.
module gpio_pin_bank_chk
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_PINS*CFG_W-1:0] cfg_flat,
    input logic [NUM_PINS-1:0]       irq_event,
    input logic                      bus_rd,
    input logic [CFG_W-1:0]          bus_rdata
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
        logic [CFG_W-1:0] w;
        logic [2:0]       m;
        assign w = cfg_flat[i*CFG_W +: CFG_W];
        assign m = w[MODE_LSB +: 3];

        // R11
        lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            w[LOCK_BIT] |=> ((w & ~CFG_LOCK_MASK) == $past(w & ~CFG_LOCK_MASK)));

        // R9
        out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (m == 3'd1 && $past(m) == 3'd1) |-> !irq_event[i]);

        // R7
        rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (m == 3'd4 && $past(m) == 3'd4 && irq_event[i]) |=> !irq_event[i]);
    end

    // R3
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> ((bus_rdata & ~CFG_RW_MASK) == '0));

    // R2
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));
endmodule

bind gpio_pin_bank gpio_pin_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_flat (cfg_flat),
    .irq_event(irq_event),
    .bus_rd   (bus_rd),
    .bus_rdata(bus_rdata)
);

// File: tb/gpio_pin_bank_bench.sv
`timescale 1ns/1ps
module gpio_pin_bank_bench;
    localparam int N  = 8;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pads = '0;
    logic [N-1:0]  pad_out, pad_oe, irq_event;
    logic [2*N-1:0] pad_func;
    logic [3*N-1:0] irq_grp;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    gpio_pin_bank #(.NUM_PINS(N), .ADDR_W(AW)) u_gpio_pin_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pads), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_func(pad_func), .irq_grp(irq_grp), .irq_event(irq_event)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(addr); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] v);
        bus_addr = AW'(addr); bus_rd = 1'b1;
        #1 v = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic set_pad(input int p, input logic v);
        @(negedge clk);
        pads[p] = v;
    endtask

    // one pad change; checks event before, on and after the expected edge
    task automatic edge_case(input int p, input logic v, input logic pulse, input string tag);
        logic [31:0] r;
        set_pad(p, v);
        @(posedge clk); @(posedge clk); #1;
        chk({tag, " early"}, 32'(irq_event[p]), 32'd0);
        rd(4*p, r);
        chk("R5 sampled level", 32'(r[0]), 32'(v));
        @(posedge clk); #1;
        chk({tag, " pulse"}, 32'(irq_event[p]), 32'(pulse));
        @(posedge clk); #1;
        chk({tag, " width"}, 32'(irq_event[p]), 32'd0);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] r;
        for (int i = 0; i < N; i++) begin
            rd(4*i, r);
            chk("R1 reset word", r, 32'h0000_000E);
        end
        chk("R1 reset oe", 32'(pad_oe), 32'd0);
        chk("R1 reset func/grp", 32'(pad_func) | 32'(irq_grp), 32'd0);
        chk("R1 reset event", 32'(irq_event), 32'd0);
    endtask

    task automatic t_output;
        logic [31:0] r;
        wr(4, 32'h3);
        #1;
        chk("R4 oe in mode 1", 32'(pad_oe[1]), 32'd1);
        chk("R4 out follows data", 32'(pad_out[1]), 32'd1);
        rd(4, r);
        chk("R5 stored bit in mode 1", r, 32'h3);
        wr(4, 32'h2);
        #1 chk("R4 out data 0", 32'(pad_out[1]), 32'd0);
        set_pad(1, 1'b1);
        repeat (5) begin
            @(posedge clk); #1 chk("R9 no event in output", 32'(irq_event[1]), 32'd0);
        end
        wr(4, 32'h0000_000F);
        #1 chk("R4 oe off in mode 7", 32'(pad_oe[1]), 32'd0);
        rd(4, r);
        chk("R5 live level in mode 7", r, 32'h0000_000F);
        set_pad(1, 1'b0);
        repeat (3) @(posedge clk);
        #1 rd(4, r);
        chk("R5 live level low", r, 32'h0000_000E);
    endtask

    task automatic t_level;
        set_pad(0, 1'b1);
        repeat (3) @(negedge clk);
        wr(0, 32'h4);
        @(posedge clk); #1 chk("R6 high level starts", 32'(irq_event[0]), 32'd1);
        repeat (4) @(posedge clk);
        #1 chk("R6 high level sustained", 32'(irq_event[0]), 32'd1);
        set_pad(0, 1'b0);
        @(posedge clk); @(posedge clk); #1 chk("R6 still set after 2 edges", 32'(irq_event[0]), 32'd1);
        @(posedge clk); #1 chk("R6 clears on 3rd edge", 32'(irq_event[0]), 32'd0);
        wr(0, 32'h6);
        @(posedge clk); #1 chk("R6 low level starts", 32'(irq_event[0]), 32'd1);
        set_pad(0, 1'b1);
        repeat (3) @(posedge clk);
        #1 chk("R6 low level clears", 32'(irq_event[0]), 32'd0);
        wr(0, 32'hE);
        set_pad(0, 1'b0);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_edges;
        wr(8, 32'h8);
        edge_case(2, 1'b1, 1'b1, "R7 rising on rise");
        edge_case(2, 1'b0, 1'b0, "R7 rising on fall");
        wr(8, 32'hA);
        edge_case(2, 1'b1, 1'b0, "R7 falling on rise");
        edge_case(2, 1'b0, 1'b1, "R7 falling on fall");
        wr(8, 32'hC);
        edge_case(2, 1'b1, 1'b1, "R8 both on rise");
        edge_case(2, 1'b0, 1'b1, "R8 both on fall");
    endtask

    task automatic t_quiet;
        logic seen;
        for (int k = 0; k < 2; k++) begin
            wr(28, (k == 0) ? 32'h0 : 32'hE);
            seen = 1'b0;
            for (int t = 0; t < 2; t++) begin
                set_pad(7, ~pads[7]);
                repeat (5) begin
                    @(posedge clk); #1 seen |= irq_event[7];
                end
            end
            chk((k == 0) ? "R9 mode 0 quiet" : "R9 mode 7 quiet", 32'(seen), 32'd0);
        end
    endtask

    task automatic t_fields;
        logic [31:0] r;
        wr(12, (32'd2 << 5) | (32'd5 << 16) | (32'd3 << 7) | 32'hE);
        #1;
        chk("R10 peripheral select", 32'(pad_func[6 +: 2]), 32'd2);
        chk("R10 interrupt group", 32'(irq_grp[9 +: 3]), 32'd5);
        rd(12, r);
        chk("R10 pull field", 32'(r[8:7]), 32'd3);
        wr(16, 32'hFFFF_FFFF);
        rd(16, r);
        chk("R3 writable mask", r, 32'h00E7_8FEE);
    endtask

    task automatic t_lock;
        logic [31:0] r;
        wr(20, 32'h0020_000E);
        wr(20, 32'h0020_0023);
        #1 chk("R11 locked mode ignored", 32'(pad_oe[5]), 32'd0);
        chk("R11 locked func ignored", 32'(pad_func[10 +: 2]), 32'd0);
        rd(20, r);
        chk("R11 locked word", r, 32'h0020_000E);
        wr(20, 32'h0000_0002);
        rd(20, r);
        chk("R11 unlock keeps fields", r, 32'h0000_000E);
        wr(20, 32'h3);
        #1 chk("R11 unlocked write applies", 32'(pad_oe[5]), 32'd1);
    endtask

    task automatic t_decode;
        logic [31:0] r;
        wr(4*6 + 1, 32'h3);
        #1 chk("R2 unaligned write ignored", 32'(pad_oe[6]), 32'd0);
        rd(24, r);
        chk("R2 pin 6 unchanged", r, 32'h0000_000E);
        rd(4*6 + 1, r);
        chk("R2 unaligned read zero", r, 32'd0);
        wr(4*N, 32'h3);
        rd(4*N, r);
        chk("R2 out of range read zero", r, 32'd0);
        chk("R2 out of range write ignored", 32'(pad_oe) & ~32'h20, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_output();
        t_level();
        t_edges();
        t_quiet();
        t_fields();
        t_lock();
        t_decode();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule